// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between on-chip logic and an external asynchronous static RAM of 524,288 bytes. Internal logic raises a one-cycle request with a write flag, a 19-bit byte address and, for writes, a data byte. The block then runs a fixed strobe sequence on the memory's active-low chip enable, output enable and write enable. Each interval in that sequence is a count of system clock cycles, computed by rounding up the memory's nanosecond minimum for the configured clock period. Read data comes back with a one-cycle valid pulse. A busy flag stays high until the memory is ready for the next access.

The data bus is split into an output byte, an output enable and an input byte, so a pad-level tri-state buffer can be placed outside. The block never drives the bus while the memory might still be driving it. Between accesses all three strobes are high, which puts the memory in standby.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip enable, output enable and write enable are all high (inactive), the data output enable is low, and busy and read-valid are low.
- R2: A read holds chip enable low, output enable low and write enable high. A write holds chip enable low, write enable low and output enable high. Output enable and write enable are never low together, and output enable is never low while chip enable is high.
- R3: The memory address changes only in a cycle where chip enable and write enable were high before and after the change. It holds its value while any strobe is low.
- R4: For a read, chip enable and output enable stay low for RD cycles, where RD is the largest of ceil(55 ns/Tclk) and ceil(30 ns/Tclk); with a 10 ns clock RD = 6. Read data is captured on the edge that releases them. Read-valid is high for exactly one cycle, RD+1 clock edges after the accepting edge. Read data equals the byte most recently written to that address, or 0x00 if the address has never been written.
- R5: For a write, chip enable and write enable fall together and stay low for WP cycles, the largest of ceil(45/50/50/25 ns / Tclk); WP = 5 at 10 ns. Write data is driven and stable from the cycle before the pulse until after it ends. Successive address changes are at least 55 ns apart.
- R6: The data output enable is never high while output enable is low. It is not high within ceil(20 ns/Tclk) cycles after the memory stops driving the bus (2 cycles at 10 ns).
- R7: Busy rises on the edge that accepts a request and stays high for 1+RD+TURN cycles on a read (TURN = ceil(20 ns/Tclk)) and 1+WP+REC cycles on a write, where REC = max(1, ceil(55 ns/Tclk)-1-WP). Requests are accepted only while busy is low.
- R8: A request raised while busy is high is ignored. It neither changes the memory address or data output, nor writes the memory, nor extends busy.
- R9: A write never produces a read-valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled while busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the access |
| req_wdata | input | 8 | Byte to write |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| busy | output | 1 | Access in progress; new requests are not accepted |
| sram_addr | output | 19 | Memory address bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | 8 | Byte driven onto the memory data bus |
| sram_dq_oe | output | 1 | Enable for the data bus driver |
| sram_dq_in | input | 8 | Byte read back from the memory data bus |

## Verification
The properties assume that reset is held for at least one clock before the first request. They also assume that the memory data input is only meaningful while the block holds output enable low. The bench keeps within these assumptions. It drives requests only at falling edges and keeps each request to a single cycle, except when it deliberately raises one during busy. Its memory model drives a recognisable filler byte whenever it is not selected for reading. The model also timestamps every strobe, address and data edge, and checks those intervals against the nanosecond minimums, not the cycle counts.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } seq_state_e;

  // Round a picosecond minimum up to whole clock cycles.
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 6,
  parameter int TURN_CYC = 2,
  parameter int WP_CYC   = 5,
  parameter int REC_CYC  = 1,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_write,
  input  logic             timer_done,
  output logic             accept,
  output logic             cap,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             busy
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    accept     = 1'b0;
    cap        = 1'b0;
    timer_load = 1'b0;
    timer_val  = '0;
    case (st_q)
      ST_IDLE: if (req) begin
        accept = 1'b1;
        st_d   = req_write ? ST_WR_SETUP : ST_RD_SETUP;
      end
      ST_RD_SETUP: begin
        st_d       = ST_RD_WAIT;
        timer_load = 1'b1;
        timer_val  = CNT_W'(RD_CYC - 1);
      end
      ST_RD_WAIT: if (timer_done) begin
        cap        = 1'b1;
        st_d       = ST_RD_TURN;
        timer_load = 1'b1;
        timer_val  = CNT_W'(TURN_CYC - 1);
      end
      ST_RD_TURN: if (timer_done) st_d = ST_IDLE;
      ST_WR_SETUP: begin
        st_d       = ST_WR_PULSE;
        timer_load = 1'b1;
        timer_val  = CNT_W'(WP_CYC - 1);
      end
      ST_WR_PULSE: if (timer_done) begin
        st_d       = ST_WR_RECOVER;
        timer_load = 1'b1;
        timer_val  = CNT_W'(REC_CYC - 1);
      end
      ST_WR_RECOVER: if (timer_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so they switch with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      busy  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ce_n  <= !((st_d == ST_RD_WAIT) || (st_d == ST_WR_PULSE));
      oe_n  <= (st_d != ST_RD_WAIT);
      we_n  <= (st_d != ST_WR_PULSE);
      dq_oe <= (st_d == ST_WR_SETUP) || (st_d == ST_WR_PULSE) ||
               (st_d == ST_WR_RECOVER);
      busy  <= (st_d != ST_IDLE);
    end
  end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              cap,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PS   = 10000,
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int T_RC_PS  = 55000,
  parameter int T_AA_PS  = 55000,
  parameter int T_ACE_PS = 55000,
  parameter int T_OE_PS  = 30000,
  parameter int T_HZ_PS  = 20000,
  parameter int T_WC_PS  = 55000,
  parameter int T_AW_PS  = 50000,
  parameter int T_CW_PS  = 50000,
  parameter int T_WP_PS  = 45000,
  parameter int T_DW_PS  = 25000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int RD_CYC = imax(1, imax(imax(cycles_for(T_AA_PS, CLK_PS),
                                             cycles_for(T_ACE_PS, CLK_PS)),
                                        imax(cycles_for(T_OE_PS, CLK_PS),
                                             cycles_for(T_RC_PS, CLK_PS) - 1)));
  localparam int TURN_CYC = imax(1, cycles_for(T_HZ_PS, CLK_PS));
  localparam int WP_CYC = imax(1, imax(imax(cycles_for(T_WP_PS, CLK_PS),
                                             cycles_for(T_CW_PS, CLK_PS)),
                                        imax(cycles_for(T_AW_PS, CLK_PS),
                                             cycles_for(T_DW_PS, CLK_PS))));
  localparam int WC_CYC  = cycles_for(T_WC_PS, CLK_PS);
  localparam int REC_CYC = imax(1, WC_CYC - 1 - WP_CYC);
  localparam int MAX_CYC = imax(imax(RD_CYC, TURN_CYC), imax(WP_CYC, REC_CYC));
  localparam int CNT_W   = imax(1, $clog2(MAX_CYC + 1));

  logic             accept, cap, timer_load, timer_done;
  logic [CNT_W-1:0] timer_val;

  sram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(timer_load), .load_val(timer_val),
    .done(timer_done)
  );

  sram_seq #(
    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .WP_CYC(WP_CYC),
    .REC_CYC(REC_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write),
    .timer_done(timer_done), .accept(accept), .cap(cap),
    .timer_load(timer_load), .timer_val(timer_val),
    .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
    .dq_oe(sram_dq_oe), .busy(busy)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .cap(cap),
    .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(sram_dq_in),
    .addr_q(sram_addr), .wdata_q(sram_dq_out), .rdata_q(rd_data),
    .valid_q(rd_valid)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int TURN_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              busy,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);
  localparam int SAT = TURN_CYC + 1;
  localparam int RW  = $clog2(SAT + 1);

  // Cycles since the memory last had its output enabled.
  logic [RW-1:0] since_rel;
  always_ff @(posedge clk) begin
    if (rst)                   since_rel <= RW'(SAT);
    else if (!sram_oe_n)       since_rel <= '0;
    else if (since_rel < RW'(SAT)) since_rel <= since_rel + 1'b1;
  end

  p_no_oe_we_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(!sram_oe_n && !sram_we_n));

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (!sram_ce_n && sram_we_n));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n || !sram_we_n || $past(!sram_ce_n)) |-> $stable(sram_addr));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_write_data_held_r5: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_dq_oe && $stable(sram_dq_out)));

  p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);

  p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (since_rel >= RW'(TURN_CYC)));

  p_idle_standby_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && req) |=> ($stable(sram_addr) && $stable(sram_dq_out)));
endmodule

bind async_sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .busy(busy), .rd_valid(rd_valid),
  .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
  .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
);

// File: tb/tb_async_sram_ctrl.sv
`timescale 1ns/1ps
module tb_async_sram_ctrl;
  localparam int AW = 19;
  localparam int DW = 8;

  function automatic int cyc(input int t_ns);
    return (t_ns + 9) / 10;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = mx(cyc(55), cyc(30));
  localparam int E_TURN = cyc(20);
  localparam int E_WP   = mx(mx(cyc(45), cyc(50)), cyc(25));
  localparam int E_REC  = (cyc(55) > E_WP + 1) ? cyc(55) - E_WP - 1 : 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, busy;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out;
  logic [DW-1:0] sram_dq_in = 8'hC3;

  async_sram_ctrl dut (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] st_mem [int];

  // Memory model with nanosecond timestamps on every edge.
  logic          p_ce, p_oe, p_we, p_dqoe, m_drv;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dq;
  realtime       t_ce, t_oe, t_we, t_addr, t_data, t_rel, now;
  int            low_cnt;

  always @(negedge clk) begin
    if (rst) begin
      p_ce = 1; p_oe = 1; p_we = 1; p_dqoe = 0; m_drv = 0;
      p_addr = sram_addr; p_dq = sram_dq_out;
      t_ce = -1000; t_oe = -1000; t_we = -1000; t_addr = -1000;
      t_data = -1000; t_rel = -1000; low_cnt = 0;
      sram_dq_in <= 8'hC3;
    end else begin
      logic drv;
      now = $realtime;
      if (!sram_oe_n && !sram_we_n) chk(0, "R2", "oe and we both low", 0, 1);
      if (!sram_oe_n && sram_ce_n) chk(0, "R2", "oe low without ce", 0, 1);
      if (sram_addr != p_addr) begin
        if (!p_ce || !p_we || !sram_ce_n || !sram_we_n)
          chk(0, "R3", "address moved under strobe", int'(sram_addr), int'(p_addr));
        if (now - t_addr < 55.0)
          chk(0, "R5", "address cycle under 55ns", int'(now - t_addr), 55);
        t_addr = now;
      end
      if (p_ce && !sram_ce_n) begin t_ce = now; low_cnt = 0; end
      if (p_oe && !sram_oe_n) t_oe = now;
      if (p_we && !sram_we_n) t_we = now;
      if (!sram_ce_n) low_cnt++;
      if (sram_dq_out != p_dq || (sram_dq_oe && !p_dqoe)) t_data = now;
      drv = !sram_ce_n && !sram_oe_n && sram_we_n;
      if (m_drv && !drv) t_rel = now;
      if (sram_dq_oe && (drv || now - t_rel < 20.0))
        chk(0, "R6", "bus contention", int'(now - t_rel), 20);
      if (!p_ce && sram_ce_n && !p_oe) begin
        chk(now - t_ce >= 55.0 && now - t_oe >= 30.0 && now - t_addr >= 55.0,
            "R4", "read access time", int'(now - t_ce), 55);
        chk(low_cnt == E_RD, "R4", "read strobe cycles", low_cnt, E_RD);
      end
      if (!p_we && (sram_we_n || sram_ce_n)) begin
        chk(now - t_we >= 45.0 && now - t_ce >= 50.0 && now - t_addr >= 50.0 &&
            now - t_data >= 25.0 && p_dqoe,
            "R5", "write pulse timing", int'(now - t_we), 45);
        chk(low_cnt == E_WP, "R5", "write strobe cycles", low_cnt, E_WP);
        st_mem[int'(p_addr)] = p_dq;
      end
      p_ce = sram_ce_n; p_oe = sram_oe_n; p_we = sram_we_n;
      p_addr = sram_addr; p_dq = sram_dq_out; p_dqoe = sram_dq_oe; m_drv = drv;
      if (drv) sram_dq_in <= st_mem.exists(int'(sram_addr)) ? st_mem[int'(sram_addr)] : 8'h00;
      else     sram_dq_in <= 8'hC3;
    end
  end

  task automatic op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit inject, input logic [DW-1:0] d2);
    int n = 0, bc = 0, vc = 0, vp = 0;
    logic [DW-1:0] vd = '0, exp;
    while (busy) @(negedge clk);
    req = 1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) req = 0;
      if (inject && n == 2) begin
        req = 1; req_write = 1; req_addr = a ^ 19'h1; req_wdata = d2;
      end
      if (inject && n == 3) req = 0;
      if (busy) bc++;
      if (rd_valid) begin vc++; vp = n; vd = rd_data; end
    end while (busy && n < 200);
    if (wr) begin
      chk(bc == 1 + E_WP + E_REC, inject ? "R8" : "R7", "write busy cycles", bc, 1 + E_WP + E_REC);
      chk(vc == 0, "R9", "valid on write", vc, 0);
      ref_mem[int'(a)] = d;
    end else begin
      exp = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
      chk(bc == 1 + E_RD + E_TURN, "R7", "read busy cycles", bc, 1 + E_RD + E_TURN);
      chk(vc == 1, "R4", "valid pulse count", vc, 1);
      chk(vp == E_RD + 2, "R4", "valid latency", vp, E_RD + 2);
      chk(vd == exp, "R4", "read data", int'(vd), int'(exp));
    end
  endtask

  initial begin
    logic [AW-1:0] pool [8];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1", "strobes in reset",
        {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    chk(!sram_dq_oe, "R1", "bus enable in reset", sram_dq_oe, 0);
    chk(!busy && !rd_valid, "R1", "busy/valid in reset", {busy, rd_valid}, 0);
    rst = 0;
    @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !busy, "R1",
        "idle after reset", {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, busy}, 28);

    op(1, 19'h00000, 8'hA5, 0, 0);
    op(1, 19'h7FFFF, 8'h5A, 0, 0);
    op(0, 19'h00000, 0, 0, 0);
    op(0, 19'h7FFFF, 0, 0, 0);
    op(0, 19'h2AAAA, 0, 0, 0);               // never written: R4 reads 0x00
    op(1, 19'h12345, 8'h3C, 1, 8'hFF);       // R8: request during busy
    op(0, 19'h12345, 0, 0, 0);
    op(0, 19'h12344, 0, 0, 0);               // R8: injected address untouched
    op(1, 19'h12345, 8'hC0, 0, 0);
    op(1, 19'h12345, 8'h0C, 0, 0);           // back-to-back writes
    op(0, 19'h12345, 0, 0, 0);
    op(1, 19'h00001, 8'h77, 0, 0);           // write right after read (R6)

    pool[0] = 19'h00000;
    pool[1] = 19'h7FFFF;
    for (int i = 2; i < 8; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = pool[$urandom % 8];
      op(1'($urandom), a, DW'($urandom), (i % 37) == 5, DW'($urandom));
    end

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule